// File: doc/BRIEF.md
# Down-Counting PWM Generator with Deferred Parameter Update

This block is one PWM generator channel. A down-counter runs from an active period value to zero and then reloads. Two comparators turn the count into two raw PWM waveforms. Each waveform is high while the count is above its own active threshold. It goes high at the reload and low when the count meets the threshold.

The period value and the two thresholds are written into shadow registers. They reach the active registers only at a counter zero, so a period in progress is never shortened or stretched. The period field and the threshold pair each have their own update mode:

- **Immediate mode:** a pending value is taken at the next zero.
- **Synchronous mode:** the value waits for a global update strobe that several generators share. It is then taken at the first zero after the strobe.

A global synchronous counter clear keeps generators with equal periods in lockstep. A debug-stall input either parks the counter once it reaches zero or is ignored, and a run enable starts and freezes counting. Single-cycle zero and reload pulses are provided for chaining to other generators and for checking.

Top module: `dcnt_pwm_gen`

## Requirements
- R1: After reset the counter, all active and shadow values and every output are zero.
- R2: With active period value L and run high, the counter steps L, L-1, ... 0 and then reloads. A zero pulse (`zero_o`) is raised once every L+1 cycles, in the cycle the counter is at zero. A period value of 399 gives a 400-cycle period.
- R3: `pwm_a_o` is high exactly while the counter is above the active A threshold, and low while the counter is zero. Period 399 with threshold 299 gives 100 high cycles out of 400.
- R4: `pwm_b_o` follows the same rule with the B threshold. Period 399 with threshold 99 gives 300 high cycles out of 400.
- R5: Immediate mode (mode input 0): a written value becomes active at the first zero pulse in a later cycle than the write. It never becomes active in the middle of a period.
- R6: Synchronous mode (mode input 1): a written value stays pending across any number of zero pulses. It becomes active at the first zero pulse in a cycle after the `upd_strobe_i` cycle. One strobe releases every pending field. A strobe with nothing pending has no effect.
- R7: `load_sync_i` selects the mode of the period field and `cmp_sync_i` selects the mode of the threshold pair. Each setting acts on its own field only.
- R8: `cnt_clr_i` sets the counter to zero at the next edge and suppresses the zero pulse and any reload in its own cycle. The counter then reaches zero in the following cycle.
- R9: With `stall_stop_i`=1, an asserted `dbg_stall_i` lets the counter run down to zero and hold there, with no zero or reload pulses. With `stall_stop_i`=0 the stall has no effect.
- R10: While `run_i` is low the counter holds its value, and no zero or reload pulses are raised.
- R11: `load_o` is high for one cycle, the cycle after each zero pulse. In that cycle the counter holds the newly active period value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Counter run enable |
| load_sync_i | input | 1 | Period field update mode: 0 immediate, 1 synchronous |
| cmp_sync_i | input | 1 | Threshold pair update mode: 0 immediate, 1 synchronous |
| stall_stop_i | input | 1 | 1: debug stall parks the counter at zero; 0: stall ignored |
| dbg_stall_i | input | 1 | Debug stall condition |
| cnt_clr_i | input | 1 | Global synchronous counter clear |
| upd_strobe_i | input | 1 | Global update strobe for synchronous mode |
| load_we_i | input | 1 | Period shadow write enable |
| load_wdata_i | input | CNT_W | Period value (period in cycles minus one) |
| cmpa_we_i | input | 1 | A threshold shadow write enable |
| cmpa_wdata_i | input | CNT_W | A threshold value |
| cmpb_we_i | input | 1 | B threshold shadow write enable |
| cmpb_wdata_i | input | CNT_W | B threshold value |
| pwm_a_o | output | 1 | Raw PWM output A |
| pwm_b_o | output | 1 | Raw PWM output B |
| zero_o | output | 1 | Zero pulse: counter at zero and advancing |
| load_o | output | 1 | Reload pulse: counter has just been reloaded |

## Verification
A wrong count or a wrongly selected reload value shows up at once in both PWM waveforms. It also shows up at the next zero pulse, which then arrives too early or too late. A shadow value copied at the wrong moment, or a pending or armed flag held wrongly, gives a period or duty that changes one period early or late, or never. The reference model therefore compares every output on every cycle, so such a fault is reported in the first cycle in which it becomes visible. Stall and clear faults appear within one cycle as a missing or extra zero pulse.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  typedef enum logic {
    UPD_IMMEDIATE = 1'b0,
    UPD_SYNCED    = 1'b1
  } upd_mode_e;

  localparam int NUM_PWM = 2;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_gen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  upd_mode_e    mode_i,
  input  logic         strobe_i,
  input  logic         zero_evt_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic [W-1:0] pick_o
);
  logic         pend_q, arm_q, go, apply;
  logic [W-1:0] sh_q, act_q;

  assign go       = pend_q && (mode_i == UPD_IMMEDIATE || arm_q);
  assign apply    = go && zero_evt_i;
  assign shadow_o = sh_q;
  assign active_o = act_q;
  assign pick_o   = go ? sh_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (we_i) sh_q <= wdata_i;
      if (apply) act_q <= sh_q;
      if (we_i) pend_q <= 1'b1;
      else if (apply) pend_q <= 1'b0;
      if (apply) arm_q <= 1'b0;
      else if (strobe_i && pend_q) arm_q <= 1'b1;
    end
  end

  // R5
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_evt_i |=> $stable(active_o));

  // R6
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == UPD_SYNCED && !arm_q && !strobe_i) |=> $stable(active_o));
endmodule

// File: rtl/pwm_dcounter.sv
module pwm_dcounter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         stall_i,
  input  logic         stall_stop_i,
  input  logic         clr_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_evt_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero, parked, tick;

  assign at_zero    = (cnt_q == '0);
  assign parked     = stall_i && stall_stop_i && at_zero;
  assign tick       = run_i && !clr_i && !parked;
  assign zero_evt_o = tick && at_zero;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick)     cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  // R9
  stall_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && stall_stop_i && cnt_o == '0) |=> cnt_o == '0);

  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] thr_i,
  output logic         pwm_o
);
  // high from reload down to the threshold match
  assign pwm_o = (cnt_i > thr_i);
endmodule

// File: rtl/dcnt_pwm_gen.sv
module dcnt_pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_sync_i,
  input  logic             cmp_sync_i,
  input  logic             stall_stop_i,
  input  logic             dbg_stall_i,
  input  logic             cnt_clr_i,
  input  logic             upd_strobe_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_wdata_i,
  input  logic             cmpa_we_i,
  input  logic [CNT_W-1:0] cmpa_wdata_i,
  input  logic             cmpb_we_i,
  input  logic [CNT_W-1:0] cmpb_wdata_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             zero_o,
  output logic             load_o
);
  localparam int CMP_W = NUM_PWM * CNT_W;

  logic [CNT_W-1:0] cnt, load_act, load_pick, load_sh;
  logic [CMP_W-1:0] cmp_act, cmp_pick, cmp_sh, cmp_wdata;
  logic [NUM_PWM-1:0] pwm_vec;
  logic zero_evt, load_q, cmp_we;

  pwm_shadow #(.W(CNT_W)) u_load_sh (
    .clk_i, .rst_ni,
    .we_i(load_we_i), .wdata_i(load_wdata_i),
    .mode_i(upd_mode_e'(load_sync_i)), .strobe_i(upd_strobe_i),
    .zero_evt_i(zero_evt),
    .shadow_o(load_sh), .active_o(load_act), .pick_o(load_pick)
  );

  // both thresholds share one pending flag; an unwritten half keeps its shadow
  assign cmp_we    = cmpa_we_i || cmpb_we_i;
  assign cmp_wdata = {cmpb_we_i ? cmpb_wdata_i : cmp_sh[CNT_W +: CNT_W],
                      cmpa_we_i ? cmpa_wdata_i : cmp_sh[0 +: CNT_W]};

  pwm_shadow #(.W(CMP_W)) u_cmp_sh (
    .clk_i, .rst_ni,
    .we_i(cmp_we), .wdata_i(cmp_wdata),
    .mode_i(upd_mode_e'(cmp_sync_i)), .strobe_i(upd_strobe_i),
    .zero_evt_i(zero_evt),
    .shadow_o(cmp_sh), .active_o(cmp_act), .pick_o(cmp_pick)
  );

  pwm_dcounter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i, .stall_i(dbg_stall_i), .stall_stop_i,
    .clr_i(cnt_clr_i), .reload_i(load_pick),
    .cnt_o(cnt), .zero_evt_o(zero_evt)
  );

  for (genvar g = 0; g < NUM_PWM; g++) begin : g_cmp
    pwm_cmp_out #(.W(CNT_W)) u_out (
      .cnt_i(cnt), .thr_i(cmp_act[g*CNT_W +: CNT_W]), .pwm_o(pwm_vec[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= zero_evt;
  end

  assign pwm_a_o = pwm_vec[0];
  assign pwm_b_o = pwm_vec[1];
  assign zero_o  = zero_evt;
  assign load_o  = load_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= load_act);

  // R3
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> (!pwm_a_o && !pwm_b_o));

  // R11
  reload_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (cnt == load_act));

  // R11
  zero_then_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> load_o);

  // R5
  cmp_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> cmp_act == $past(cmp_pick));
endmodule

// File: tb/dcnt_pwm_gen_tb_top.sv
module dcnt_pwm_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic run = 0, ls = 0, cs = 0, ss = 0, stall = 0, clr = 0, strobe = 0;
  logic lwe = 0, awe = 0, bwe = 0;
  logic [15:0] lwd = '0, awd = '0, bwd = '0;
  logic pwm_a, pwm_b, zero, load;

  always #10 clk_i = ~clk_i;

  dcnt_pwm_gen #(.CNT_W(16)) dut_i (
    .clk_i, .rst_ni,
    .run_i(run), .load_sync_i(ls), .cmp_sync_i(cs), .stall_stop_i(ss),
    .dbg_stall_i(stall), .cnt_clr_i(clr), .upd_strobe_i(strobe),
    .load_we_i(lwe), .load_wdata_i(lwd),
    .cmpa_we_i(awe), .cmpa_wdata_i(awd),
    .cmpb_we_i(bwe), .cmpb_wdata_i(bwd),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .zero_o(zero), .load_o(load)
  );

  int n_chk = 0, n_bad = 0;
  // reference model state
  int m_cnt = 0, m_lact = 0, m_lsh = 0, m_cmpa = 0, m_cmpb = 0, m_ash = 0, m_bsh = 0;
  bit m_lpend = 0, m_larm = 0, m_cpend = 0, m_carm = 0, m_ld = 0;
  bit s_zero, s_load, s_a, s_b;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit tick, e_zero, e_a, e_b, e_load, lgo, cgo;
    #2;
    tick   = run && !clr && !(stall && ss && m_cnt == 0);
    e_zero = tick && m_cnt == 0;
    e_a    = m_cnt > m_cmpa;
    e_b    = m_cnt > m_cmpb;
    e_load = m_ld;
    s_zero = zero; s_load = load; s_a = pwm_a; s_b = pwm_b;
    chk(s_zero == e_zero, "R2 zero_o", s_zero, e_zero);
    chk(s_a == e_a, "R3 pwm_a_o", s_a, e_a);
    chk(s_b == e_b, "R4 pwm_b_o", s_b, e_b);
    chk(s_load == e_load, "R11 load_o", s_load, e_load);
    @(posedge clk_i);
    lgo = m_lpend && (!ls || m_larm);
    cgo = m_cpend && (!cs || m_carm);
    if (clr) m_cnt = 0;
    else if (tick) begin
      if (m_cnt == 0) begin
        m_cnt = lgo ? m_lsh : m_lact;
        if (lgo) m_lact = m_lsh;
        if (cgo) begin m_cmpa = m_ash; m_cmpb = m_bsh; end
      end else m_cnt--;
    end
    if (e_zero && lgo) m_larm = 0; else if (strobe && m_lpend) m_larm = 1;
    if (e_zero && cgo) m_carm = 0; else if (strobe && m_cpend) m_carm = 1;
    if (lwe) m_lpend = 1; else if (e_zero && lgo) m_lpend = 0;
    if (awe || bwe) m_cpend = 1; else if (e_zero && cgo) m_cpend = 0;
    if (lwe) m_lsh = int'(lwd);
    if (awe) m_ash = int'(awd);
    if (bwe) m_bsh = int'(bwd);
    m_ld = e_zero;
    @(negedge clk_i);
  endtask

  task automatic wr_load(input int v);
    lwe = 1; lwd = 16'(v); step(); lwe = 0;
  endtask

  task automatic wr_cmp(input int a, input int b);
    awe = 1; awd = 16'(a); bwe = 1; bwd = 16'(b); step(); awe = 0; bwe = 0;
  endtask

  task automatic pulse_strobe();
    strobe = 1; step(); strobe = 0;
  endtask

  task automatic wait_load();
    do step(); while (!s_load);
  endtask

  task automatic meas(output int per, output int ah, output int bh);
    per = 0; ah = 0; bh = 0;
    wait_load();
    do begin per++; ah += s_a; bh += s_b; step(); end while (!s_load);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int per, ah, bh, n, cz, cl, ca, chg;
    bit first_a;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #2;
    // R1 reset state
    chk(!pwm_a && !pwm_b && !zero && !load, "R1 reset outputs", {pwm_a, pwm_b, zero, load}, 0);
    @(negedge clk_i);

    // configure while stopped; R10 no events
    wr_load(399); wr_cmp(299, 99);
    cz = 0;
    repeat (5) begin step(); cz += s_zero + s_load; end
    chk(cz == 0, "R10 stopped events", cz, 0);
    run = 1;
    meas(per, ah, bh);
    chk(per == 400, "R2 period", per, 400);
    chk(ah == 100, "R3 high cycles", ah, 100);
    chk(bh == 300, "R4 high cycles", bh, 300);

    // R5 immediate write mid-period does not cut the period short
    wait_load();
    n = 0;
    repeat (10) begin step(); n++; end
    wr_load(99); n++;
    do begin step(); n++; end while (!s_load);
    chk(n == 400, "R5 running period kept", n, 400);
    meas(per, ah, bh);
    chk(per == 100, "R5 new period", per, 100);

    // R6/R7 period synchronous, thresholds immediate
    ls = 1;
    wr_load(199);
    wr_cmp(49, 79);
    meas(per, ah, bh);
    chk(per == 100, "R6 held period", per, 100);
    chk(ah == 50, "R7 threshold A immediate", ah, 50);
    chk(bh == 20, "R7 threshold B immediate", bh, 20);
    meas(per, ah, bh);
    chk(per == 100, "R6 held over zeros", per, 100);
    pulse_strobe();
    meas(per, ah, bh);
    chk(per == 200, "R6 after strobe", per, 200);
    chk(ah == 150, "R3 duty at 200", ah, 150);

    // both synchronous, one strobe releases all
    cs = 1;
    wr_load(59); wr_cmp(29, 9);
    meas(per, ah, bh);
    chk(per == 200, "R6 both held", per, 200);
    chk(ah == 150, "R7 threshold held", ah, 150);
    pulse_strobe();
    meas(per, ah, bh);
    chk(per == 60, "R6 single strobe period", per, 60);
    chk(ah == 30, "R6 single strobe A", ah, 30);
    chk(bh == 50, "R6 single strobe B", bh, 50);
    // strobe with nothing pending
    pulse_strobe();
    meas(per, ah, bh);
    chk(per == 60, "R6 idle strobe", per, 60);

    // R8 global clear
    repeat (7) step();
    clr = 1; step(); clr = 0;
    step();
    chk(s_zero, "R8 zero after clear", s_zero, 1);
    step();
    chk(s_load, "R11 load after zero", s_load, 1);

    // R9 stall parks at zero
    ss = 1; stall = 1;
    repeat (100) step();
    cz = 0; cl = 0; ca = 0;
    repeat (100) begin step(); cz += s_zero; cl += s_load; ca += s_a; end
    chk(cz == 0, "R9 parked zero pulses", cz, 0);
    chk(cl == 0, "R9 parked load pulses", cl, 0);
    chk(ca == 0, "R9 parked output A", ca, 0);
    stall = 0;
    step();
    chk(s_zero, "R9 resume at zero", s_zero, 1);
    ss = 0; stall = 1;
    cz = 0;
    repeat (120) begin step(); cz += s_zero; end
    chk(cz == 2, "R9 stall ignored", cz, 2);
    stall = 0;

    // R10 run low freezes
    repeat (17) step();
    run = 0;
    step();
    cz = 0; chg = 0;
    first_a = s_a;
    repeat (50) begin step(); cz += s_zero + s_load; chg += (s_a != first_a); end
    chk(cz == 0, "R10 frozen events", cz, 0);
    chk(chg == 0, "R10 frozen output", chg, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule